// File: doc/BRIEF.md
# Configurable GPIO Interrupt Detector

This block watches a port of general-purpose input pins and turns selected pin activity into interrupt requests. Three configuration bits per pin pick the trigger condition: a held high level, a held low level, a rising edge, a falling edge, or any change. Detected events are caught in a sticky per-pin status register. Software clears that register one bit at a time with a write-one-to-clear strobe.

An enable mask per pin selects which status bits reach the interrupt line. The masked status is the raw status gated by that mask. A single interrupt output is the OR of all masked bits. Both are combinational from the status and mask registers, so a mask change shows at the output in the same cycle. The pin inputs are assumed to be already synchronized to the clock. The register bus decoder that drives the configuration vectors and the clear strobe lives outside this block.

Top module: `gpio_irq_detect`

## Requirements
- R1: A `cfg_level` bit of 1 puts that pin in level mode and 0 puts it in edge mode; each pin is configured independently.
- R2: In edge mode with the `cfg_both` bit set, any change of the pin between two consecutive clock edges sets its raw status bit, whatever `cfg_pol` holds.
- R3: In level mode with `cfg_pol` = 1, a pin sampled high at a clock edge sets its raw status bit at that edge.
- R4: In level mode with `cfg_pol` = 0, a pin sampled low at a clock edge sets its raw status bit at that edge.
- R5: In edge mode with `cfg_both` clear, `cfg_pol` = 1 detects only rising edges (0 then 1) and `cfg_pol` = 0 detects only falling edges (1 then 0). In level mode `cfg_both` has no effect.
- R6: Raw status bits are sticky. A bit falls only at a clock edge where `clr_we` is 1 and the matching `clr_bits` bit is 1. `clr_bits` has no effect while `clr_we` is 0.
- R7: `masked_status` equals `raw_status` AND `cfg_mask` at all times, with no clock between them.
- R8: `irq` is 1 exactly when any `masked_status` bit is 1, and it follows a change of `cfg_mask` in the same cycle.
- R9: While `rst_n` is low, the raw status and the stored previous pin sample are 0, so `raw_status`, `masked_status` and `irq` are 0. Reset is released on the second clock edge after `rst_n` rises.
- R10: When a detected event and a clear of the same bit meet at one clock edge, the bit ends up set.
- R11: An edge is found by comparing the pin sampled at a clock edge with the value the pin had at the previous clock edge. The resulting status bit appears right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pin_in | input | NPINS | Synchronized pin values |
| cfg_level | input | NPINS | 1 = level mode, 0 = edge mode, per pin |
| cfg_both | input | NPINS | In edge mode, 1 = trigger on either edge |
| cfg_pol | input | NPINS | Polarity: high level or rising edge when 1 |
| cfg_mask | input | NPINS | Per-pin interrupt enable |
| clr_we | input | 1 | Clear strobe |
| clr_bits | input | NPINS | Bits to clear when `clr_we` is 1 |
| raw_status | output | NPINS | Sticky detected-event status |
| masked_status | output | NPINS | `raw_status` AND `cfg_mask` |
| irq | output | 1 | OR of `masked_status` |

## Verification
The bench sweeps all five trigger modes over pin patterns that contain every (previous, current) pair on some pin. Each step clears all status bits at the same edge where the previous value is held. This exposes three kinds of bug. A design that lets the clear beat a level event loses a held level. A design that mixes up rising and falling, or honours `cfg_both` in level mode, sets the wrong bits. A design that compares against a stale sample reports edges one cycle late.

Further directed cases cover the rest. One holds a status bit across idle cycles and clears part of the vector. Another presents `clr_bits` without the strobe, where a leaky decode would drop status. Another flips the mask between clocks, where a registered interrupt path would lag by a cycle.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  typedef enum logic [2:0] {
    TRIG_LEVEL_LO = 3'd0,
    TRIG_LEVEL_HI = 3'd1,
    TRIG_EDGE_FALL = 3'd2,
    TRIG_EDGE_RISE = 3'd3,
    TRIG_EDGE_ANY = 3'd4
  } trig_mode_e;

  function automatic trig_mode_e trig_decode(input logic level, input logic both, input logic pol);
    trig_mode_e m;
    if (level)      m = pol ? TRIG_LEVEL_HI : TRIG_LEVEL_LO;
    else if (both)  m = TRIG_EDGE_ANY;
    else            m = pol ? TRIG_EDGE_RISE : TRIG_EDGE_FALL;
    return m;
  endfunction

endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/gpio_pin_event.sv
module gpio_pin_event
  import gpio_irq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic level_sel,
  input  logic both_sel,
  input  logic pol_sel,
  output logic evt
);
  logic       pin_q;
  trig_mode_e mode;

  // previous-sample register, refreshed every cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_q <= 1'b0;
    else        pin_q <= pin;
  end

  always_comb begin
    mode = trig_decode(level_sel, both_sel, pol_sel);
    unique case (mode)
      TRIG_LEVEL_LO:  evt = ~pin;
      TRIG_LEVEL_HI:  evt = pin;
      TRIG_EDGE_FALL: evt = pin_q & ~pin;
      TRIG_EDGE_RISE: evt = ~pin_q & pin;
      TRIG_EDGE_ANY:  evt = pin_q ^ pin;
      default:        evt = 1'b0;
    endcase
  end
endmodule

// File: rtl/gpio_status_reg.sv
module gpio_status_reg #(
  parameter int NPINS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] evt,
  input  logic             clr_we,
  input  logic [NPINS-1:0] clr_bits,
  output logic [NPINS-1:0] raw_q
);
  logic [NPINS-1:0] clr_mask;
  logic [NPINS-1:0] raw_d;
  logic             upd_en;

  always_comb begin
    clr_mask = clr_we ? clr_bits : '0;
    raw_d    = (raw_q & ~clr_mask) | evt;   // set has priority
    upd_en   = clr_we | (|evt);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      raw_q <= '0;
    else if (upd_en) raw_q <= raw_d;
  end

  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(raw_q) & ~$past(clr_mask)) & ~raw_q) == '0)); // R6
  AST_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(evt) & ~raw_q) == '0)); // R10
  AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((raw_q & $past(clr_mask & ~evt)) == '0)); // R6
endmodule

// File: rtl/gpio_irq_combine.sv
module gpio_irq_combine #(
  parameter int NPINS = 8
) (
  input  logic [NPINS-1:0] raw,
  input  logic [NPINS-1:0] mask,
  output logic [NPINS-1:0] masked,
  output logic             irq
);
  always_comb begin
    masked = raw & mask;
    irq    = |masked;
  end
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
  parameter int NPINS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pin_in,
  input  logic [NPINS-1:0] cfg_level,
  input  logic [NPINS-1:0] cfg_both,
  input  logic [NPINS-1:0] cfg_pol,
  input  logic [NPINS-1:0] cfg_mask,
  input  logic             clr_we,
  input  logic [NPINS-1:0] clr_bits,
  output logic [NPINS-1:0] raw_status,
  output logic [NPINS-1:0] masked_status,
  output logic             irq
);
  logic             rst_sync_n;
  logic [NPINS-1:0] evt_vec;

  gpio_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    gpio_pin_event u_evt (
      .clk       (clk),
      .rst_n     (rst_sync_n),
      .pin       (pin_in[i]),
      .level_sel (cfg_level[i]),
      .both_sel  (cfg_both[i]),
      .pol_sel   (cfg_pol[i]),
      .evt       (evt_vec[i])
    );
  end

  gpio_status_reg #(.NPINS(NPINS)) u_status (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .evt      (evt_vec),
    .clr_we   (clr_we),
    .clr_bits (clr_bits),
    .raw_q    (raw_status)
  );

  gpio_irq_combine #(.NPINS(NPINS)) u_comb (
    .raw    (raw_status),
    .mask   (cfg_mask),
    .masked (masked_status),
    .irq    (irq)
  );

  AST_LEVEL_HIGH: assert property (@(posedge clk) disable iff (!rst_sync_n)
    1'b1 |=> (($past(cfg_level & cfg_pol & pin_in) & ~raw_status) == '0)); // R3
  AST_LEVEL_LOW: assert property (@(posedge clk) disable iff (!rst_sync_n)
    1'b1 |=> (($past(cfg_level & ~cfg_pol & ~pin_in) & ~raw_status) == '0)); // R4
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_sync_n |-> (raw_status == '0 && !irq)); // R9
endmodule

// File: tb/gpio_irq_detect_tb.sv
module gpio_irq_detect_tb_top;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [N-1:0] pin_in, cfg_level, cfg_both, cfg_pol, cfg_mask, clr_bits;
  logic         clr_we;
  logic [N-1:0] raw_status, masked_status;
  logic         irq;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  always #2.5 clk = ~clk;   // 200 MHz

  gpio_irq_detect #(.NPINS(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .cfg_level(cfg_level),
    .cfg_both(cfg_both), .cfg_pol(cfg_pol), .cfg_mask(cfg_mask),
    .clr_we(clr_we), .clr_bits(clr_bits), .raw_status(raw_status),
    .masked_status(masked_status), .irq(irq)
  );

  function automatic logic [N-1:0] model_evt(input logic [N-1:0] lv, input logic [N-1:0] bo,
                                             input logic [N-1:0] po, input logic [N-1:0] cur,
                                             input logic [N-1:0] prev);
    logic [N-1:0] lvl_hit, edge_hit;
    lvl_hit  = po & cur | ~po & ~cur;
    edge_hit = bo & (cur ^ prev) | ~bo & po & cur & ~prev | ~bo & ~po & ~cur & prev;
    return lv & lvl_hit | ~lv & edge_hit;
  endfunction

  task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_outs(input string req, input logic [N-1:0] exp_raw);
    check({req, " raw"}, raw_status, exp_raw);
    check("R7 masked", masked_status, exp_raw & cfg_mask);
    check("R8 irq", {{(N-1){1'b0}}, irq}, {{(N-1){1'b0}}, |(exp_raw & cfg_mask)});
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_mode(input int m);
    case (m)
      0: begin cfg_level = '1; cfg_both = '0; cfg_pol = '0; end // low level
      1: begin cfg_level = '1; cfg_both = '1; cfg_pol = '1; end // high level, both ignored
      2: begin cfg_level = '0; cfg_both = '0; cfg_pol = '0; end // falling
      3: begin cfg_level = '0; cfg_both = '0; cfg_pol = '1; end // rising
      4: begin cfg_level = '0; cfg_both = '1; cfg_pol = '0; end // any edge
      default: begin cfg_level = 8'h0F; cfg_both = 8'hC3; cfg_pol = 8'h5A; end // mixed
    endcase
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] pats [4];
    logic [N-1:0] e0, e1;
    pats[0] = 8'h00; pats[1] = 8'hFF; pats[2] = 8'h33; pats[3] = 8'h55;
    rst_n = 1'b0; pin_in = '0; cfg_level = '1; cfg_both = '0; cfg_pol = '0;
    cfg_mask = '1; clr_we = 1'b0; clr_bits = '0;
    repeat (3) step();
    // R9: low-level config on low pins would trigger, but reset holds status at 0
    check_outs("R9 reset", '0);
    rst_n = 1'b1;
    step();
    check_outs("R9 reset release", '0);
    cfg_level = '0;
    step();
    step();

    // R1 R2 R3 R4 R5 R10 R11 sweep
    for (int m = 0; m < 6; m++) begin
      for (int a = 0; a < 4; a++) begin
        for (int b = 0; b < 4; b++) begin
          set_mode(m);
          cfg_mask = pats[a] ^ pats[b] ^ 8'h96;
          pin_in = pats[a]; clr_we = 1'b0;
          step(); step();
          clr_we = 1'b1; clr_bits = '1;
          step();
          e0 = model_evt(cfg_level, cfg_both, cfg_pol, pats[a], pats[a]);
          check_outs("R10 set-wins/R1", e0);
          clr_we = 1'b0; pin_in = pats[b];
          step();
          e1 = e0 | model_evt(cfg_level, cfg_both, cfg_pol, pats[b], pats[a]);
          check_outs("R11 R2 R3 R4 R5 edge/level", e1);
        end
      end
    end

    // R6 sticky: rising edge on all pins, then pins fall, status held
    set_mode(3); cfg_mask = '1; pin_in = '0; clr_we = 1'b1; clr_bits = '1;
    step(); clr_we = 1'b0; step();
    check_outs("R6 cleared", '0);
    pin_in = '1; step();
    pin_in = '0; repeat (4) step();
    check_outs("R6 sticky", 8'hFF);
    clr_bits = 8'h0F; clr_we = 1'b0; step();
    check_outs("R6 clr_bits without strobe", 8'hFF);
    clr_we = 1'b1; step(); clr_we = 1'b0;
    check_outs("R6 partial clear", 8'hF0);

    // R7 R8: mask change visible without a clock edge
    cfg_mask = 8'h0F; #1;
    check("R8 irq mask off", {7'b0, irq}, 8'h00);
    check("R7 masked off", masked_status, 8'h00);
    cfg_mask = 8'h80; #1;
    check("R8 irq mask on", {7'b0, irq}, 8'h01);
    check("R7 masked on", masked_status, 8'h80);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule